// File: doc/BRIEF.md
# Block-Lockable EEPROM Write Controller

This block sits between a microcontroller's multiplexed address/data bus and a byte-wide 8192-entry nonvolatile array. The array is modelled here as a register array. The host first presents the low address byte on the shared bus with the latch strobe. It then issues a read or write strobe, with the upper five address bits on dedicated lines. The array is split into eight 1 KB blocks. Each block carries a lock bit, and a locked block refuses every write.

Writes are gathered into a 32-byte page buffer. When the write strobes stop arriving for a set number of cycles, the block enters an internal programming phase of fixed length. At the end of that phase the buffered bytes are copied into the array. While programming runs, reads return a status byte in which one bit flips on every read, so the host can poll for completion.

Two command sequences are written to fixed addresses. The first enables write protection and arms the next page for writing. The second sets or clears lock bits for any group of blocks.

Top module: `blk_lock_eeprom`

## Requirements
- R1: After reset, `rd_data` is 0, `busy` is 0, no block is locked and write protection is off, so a plain write is accepted.
- R2: The full 13-bit address is `{addr_hi, low byte}`. The low byte is the value of `ad_in` captured on the last clock edge at which `ale` was high.
- R3: With protection off, a write that is not consumed by a command sequence is buffered and later stored in the array.
- R4: The first buffered write fixes the page, which is address bits 12..5. Later writes to the same page are added to the buffer, and the last value written to an offset wins. Writes to any other page are dropped until the commit.
- R5: `busy` rises WIN_CYC clock edges after the edge of the last buffered write and stays high for PROG_CYC edges. The array holds the new bytes once `busy` has fallen.
- R6: A read while `busy` is high returns the last buffered byte with bit 6 replaced by a toggle. The toggle is 0 on the first such read and inverts on each later read.
- R7: Write strobes while `busy` is high have no effect on the buffer, the status byte, the array, the lock bits or the command detector.
- R8: Writing 0xAA to 0x1555, then 0x55 to 0x0AAA, then 0xA0 to 0x1555 turns protection on and arms one page write. Once protection is on, a write that has no arming sequence before it is ignored.
- R9: The sequence 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, then M@0x1555 locks every block whose bit is set in M. Bit n of M selects block n. Using 0x40 in place of 0x80 at step three unlocks those blocks instead.
- R10: A write to a locked block, where the block is address bits 12..10, is discarded and starts no programming, even when the page is armed. An armed page stays armed after such a discard.
- R11: A write that does not match the next step of a sequence returns the detector to idle. That write is then handled as an ordinary write, unless it is 0xAA@0x1555, which starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable for read and write strobes |
| ale | input | 1 | Address latch strobe; captures `ad_in` as the low address byte |
| wr_stb | input | 1 | Write strobe; `ad_in` carries the data |
| rd_stb | input | 1 | Read strobe |
| ad_in | input | 8 | Multiplexed address/data input |
| addr_hi | input | 5 | Address bits 12..8 |
| rd_data | output | 8 | Read result, registered |
| busy | output | 1 | Internal programming in progress |

## Verification
`rd_data` changes on the clock edge that samples a read strobe. `busy` rises on the WIN_CYC-th edge after the last buffered write and falls PROG_CYC edges later, and only then do reads see the new array bytes. The bench keeps a behavioural model that advances on the same edge as the design. It compares `busy` and `rd_data` 5 ns after each rising edge, and inputs change only on falling edges. Directed checks count falling edges to confirm both delays exactly. They also read the array back only after `busy` has dropped.

// File: rtl/blw_pkg.sv
package blw_pkg;
  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 8;
  localparam int BLK_W   = 3;
  localparam int NBLK    = 1 << BLK_W;
  localparam int PAGE_W  = 5;
  localparam int NPAGE_B = 1 << PAGE_W;
  localparam int PG_W    = ADDR_W - PAGE_W;
  localparam int HI_W    = ADDR_W - DATA_W;
  localparam int TOG_BIT = 6;

  localparam logic [ADDR_W-1:0] CMD_ADDR_A = 13'h1555;
  localparam logic [ADDR_W-1:0] CMD_ADDR_B = 13'h0AAA;
  localparam logic [DATA_W-1:0] KEY_1      = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_2      = 8'h55;
  localparam logic [DATA_W-1:0] OP_ARM     = 8'hA0;
  localparam logic [DATA_W-1:0] OP_LOCK    = 8'h80;
  localparam logic [DATA_W-1:0] OP_UNLOCK  = 8'h40;

  typedef enum logic [2:0] {SQ_IDLE, SQ_K1, SQ_K2, SQ_L3, SQ_L4, SQ_L5} seq_st_t;
  typedef enum logic [1:0] {PG_IDLE, PG_LOAD, PG_PROG} pg_st_t;
endpackage

// File: rtl/blw_cmd_seq.sv
module blw_cmd_seq
  import blw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              take,
  output logic              arm_p,
  output logic              lock_p,
  output logic              unlock_p
);
  seq_st_t st_q, st_d;
  logic    unl_q, unl_d;
  logic    is_k1, is_k2, at_a;

  assign is_k1 = (addr == CMD_ADDR_A) && (data == KEY_1);
  assign is_k2 = (addr == CMD_ADDR_B) && (data == KEY_2);
  assign at_a  = (addr == CMD_ADDR_A);

  always_comb begin
    st_d     = st_q;
    unl_d    = unl_q;
    take     = 1'b0;
    arm_p    = 1'b0;
    lock_p   = 1'b0;
    unlock_p = 1'b0;
    if (!en) begin
      st_d = SQ_IDLE;
    end else if (wr) begin
      take = 1'b1;
      case (st_q)
        SQ_K1: if (is_k2) st_d = SQ_K2; else take = 1'b0;
        SQ_K2: begin
          if (at_a && data == OP_ARM) begin
            st_d = SQ_IDLE; arm_p = 1'b1;
          end else if (at_a && data == OP_LOCK) begin
            st_d = SQ_L3; unl_d = 1'b0;
          end else if (at_a && data == OP_UNLOCK) begin
            st_d = SQ_L3; unl_d = 1'b1;
          end else take = 1'b0;
        end
        SQ_L3: if (is_k1) st_d = SQ_L4; else take = 1'b0;
        SQ_L4: if (is_k2) st_d = SQ_L5; else take = 1'b0;
        SQ_L5: begin
          if (at_a) begin
            st_d = SQ_IDLE; lock_p = ~unl_q; unlock_p = unl_q;
          end else take = 1'b0;
        end
        default: take = 1'b0;
      endcase
      // mismatch or idle: restart from this write
      if (!take) begin
        take = is_k1;
        st_d = is_k1 ? SQ_K1 : SQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      unl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      unl_q <= unl_d;
    end
  end

  // R9
  lk_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_L3 && $past(st_q) != SQ_L3) |-> $past(st_q) == SQ_K2);
endmodule

// File: rtl/blw_page.sv
module blw_page
  import blw_pkg::*;
#(
  parameter int WIN_CYC  = 100,
  parameter int PROG_CYC = 200
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               data,
  output logic                            loading,
  output logic                            busy,
  output logic                            commit,
  output logic [PG_W-1:0]                 cur_page,
  output logic [NPAGE_B-1:0][DATA_W-1:0]  bdat,
  output logic [NPAGE_B-1:0]              bval
);
  localparam int WCW = $clog2(WIN_CYC);
  localparam int PCW = $clog2(PROG_CYC);

  pg_st_t         st_q, st_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic [PAGE_W-1:0] off;

  assign off     = addr[PAGE_W-1:0];
  assign loading = (st_q == PG_LOAD);
  assign busy    = (st_q == PG_PROG);

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    pcnt_d = pcnt_q;
    commit = 1'b0;
    case (st_q)
      PG_IDLE: if (load) begin st_d = PG_LOAD; wcnt_d = '0; end
      PG_LOAD: begin
        if (load) wcnt_d = '0;
        else if (wcnt_q == WCW'(WIN_CYC - 1)) begin st_d = PG_PROG; pcnt_d = '0; end
        else wcnt_d = wcnt_q + 1'b1;
      end
      PG_PROG: begin
        if (pcnt_q == PCW'(PROG_CYC - 1)) begin st_d = PG_IDLE; commit = 1'b1; end
        else pcnt_d = pcnt_q + 1'b1;
      end
      default: st_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PG_IDLE;
      wcnt_q   <= '0;
      pcnt_q   <= '0;
      bval     <= '0;
      cur_page <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      pcnt_q <= pcnt_d;
      if (commit) bval <= '0;
      else if (load) begin
        if (st_q == PG_IDLE) begin
          cur_page <= addr[ADDR_W-1:PAGE_W];
          bval     <= '0;
        end
        bval[off] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) bdat[off] <= data;
  end

  // R5
  prog_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(st_q) == PG_LOAD);
  // R7
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(bval) && $stable(bdat)));
  // R4
  load_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loading |-> (bval != '0));
endmodule

// File: rtl/blk_lock_eeprom.sv
module blk_lock_eeprom
  import blw_pkg::*;
#(
  parameter int WIN_CYC  = 100,
  parameter int PROG_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              ale,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  logic [DATA_W-1:0] lo_q, last_q, last_d, rd_d, stat;
  logic [ADDR_W-1:0] addr;
  logic [BLK_W-1:0]  blk;
  logic [NBLK-1:0]   lock_q, lock_d;
  logic sdp_q, sdp_d, armed_q, armed_d, tog_q, tog_d;
  logic wr_ev, rd_ev, seq_en, take, arm_p, lock_p, unlock_p;
  logic load_ok, loading, commit, same_pg;
  logic [PG_W-1:0] cur_page;
  logic [NPAGE_B-1:0][DATA_W-1:0] bdat;
  logic [NPAGE_B-1:0] bval;
  logic [DATA_W-1:0] mem [1 << ADDR_W];

  assign addr    = {addr_hi, lo_q};
  assign blk     = addr[ADDR_W-1 -: BLK_W];
  assign wr_ev   = ce & wr_stb & ~busy;
  assign rd_ev   = ce & rd_stb;
  assign seq_en  = ~loading & ~busy & ~armed_q;
  assign same_pg = ~loading | (addr[ADDR_W-1:PAGE_W] == cur_page);
  assign load_ok = wr_ev & ~take & (armed_q | ~sdp_q) & ~lock_q[blk] & same_pg;

  blw_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(seq_en), .wr(wr_ev), .addr(addr), .data(ad_in),
    .take(take), .arm_p(arm_p), .lock_p(lock_p), .unlock_p(unlock_p)
  );

  blw_page #(.WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_page (
    .clk(clk), .rst_n(rst_n), .load(load_ok), .addr(addr), .data(ad_in),
    .loading(loading), .busy(busy), .commit(commit), .cur_page(cur_page),
    .bdat(bdat), .bval(bval)
  );

  always_comb begin
    lock_d  = lock_q;
    if (lock_p)   lock_d = lock_q | ad_in[NBLK-1:0];
    if (unlock_p) lock_d = lock_q & ~ad_in[NBLK-1:0];
    sdp_d   = sdp_q | arm_p;
    armed_d = arm_p ? 1'b1 : (commit ? 1'b0 : armed_q);
    last_d  = load_ok ? ad_in : last_q;
    tog_d   = busy ? (tog_q ^ rd_ev) : 1'b0;
    stat    = last_q;
    stat[TOG_BIT] = tog_q;
    rd_d    = rd_data;
    if (rd_ev) rd_d = busy ? stat : mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      lock_q  <= '0;
      sdp_q   <= 1'b0;
      armed_q <= 1'b0;
      last_q  <= '0;
      tog_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      if (ale) lo_q <= ad_in;
      lock_q  <= lock_d;
      sdp_q   <= sdp_d;
      armed_q <= armed_d;
      last_q  <= last_d;
      tog_q   <= tog_d;
      rd_data <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < NPAGE_B; i++) begin
        if (bval[i]) mem[{cur_page, PAGE_W'(i)}] <= bdat[i];
      end
    end
  end

  // R8
  sdp_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_p |=> sdp_q);
  // R7
  busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ce && wr_stb) |=> $stable(last_q));
endmodule

// File: tb/blk_lock_eeprom_tb_top.sv
module blk_lock_eeprom_tb_top;
  localparam int W = 20;
  localparam int P = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b1, ale = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] ad_in = '0;
  logic [4:0] addr_hi = '0;
  logic [7:0] rd_data;
  logic busy;

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  blk_lock_eeprom #(.WIN_CYC(W), .PROG_CYC(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .ale(ale), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .ad_in(ad_in), .addr_hi(addr_hi), .rd_data(rd_data), .busy(busy)
  );

  // behavioural reference model
  logic [7:0] mmem [8192];
  logic [7:0] pbuf [32];
  bit   pval [32];
  int   mst, wc, pc, mstep, mpage;
  bit   munl, msdp, marmed, mtog;
  logic [7:0] mlock, mlast, mlo, exp_rd;

  initial for (int i = 0; i < 8192; i++) mmem[i] = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; wc = 0; pc = 0; mstep = 0; mpage = 0; munl = 0; msdp = 0;
      marmed = 0; mtog = 0; mlock = 0; mlast = 0; mlo = 0; exp_rd = 0;
      for (int i = 0; i < 32; i++) pval[i] = 0;
    end else begin
      bit mb, wr, rd, take, k1, k2, ata, load;
      int a;
      logic [7:0] d;
      mb = (mst == 2);
      wr = ce && wr_stb && !mb;
      rd = ce && rd_stb;
      a = {addr_hi, mlo};
      d = ad_in;
      take = 0;
      if (mst == 0 && !marmed) begin
        if (wr) begin
          k1 = (a == 'h1555 && d == 8'hAA);
          k2 = (a == 'h0AAA && d == 8'h55);
          ata = (a == 'h1555);
          if (mstep == 1 && k2) begin mstep = 2; take = 1; end
          else if (mstep == 2 && ata && d == 8'hA0) begin msdp = 1; marmed = 1; mstep = 0; take = 1; end
          else if (mstep == 2 && ata && (d == 8'h80 || d == 8'h40)) begin munl = (d == 8'h40); mstep = 3; take = 1; end
          else if (mstep == 3 && k1) begin mstep = 4; take = 1; end
          else if (mstep == 4 && k2) begin mstep = 5; take = 1; end
          else if (mstep == 5 && ata) begin
            mlock = munl ? (mlock & ~d) : (mlock | d);
            mstep = 0; take = 1;
          end
          if (!take) begin mstep = k1 ? 1 : 0; take = k1; end
        end
      end else mstep = 0;
      load = wr && !take && (marmed || !msdp) && !mlock[a / 1024]
             && (mst == 0 || (a / 32) == mpage);
      if (rd) exp_rd = mb ? {mlast[7], mtog, mlast[5:0]} : mmem[a];
      mtog = mb ? (mtog ^ rd) : 1'b0;
      if (mst == 2) begin
        if (pc == P - 1) begin
          for (int i = 0; i < 32; i++) if (pval[i]) mmem[mpage * 32 + i] = pbuf[i];
          for (int i = 0; i < 32; i++) pval[i] = 0;
          marmed = 0; mst = 0;
        end else pc++;
      end else if (mst == 1) begin
        if (load) wc = 0;
        else if (wc == W - 1) begin mst = 2; pc = 0; end
        else wc++;
      end
      if (load) begin
        if (mst == 0) begin
          mst = 1; wc = 0; mpage = a / 32;
          for (int i = 0; i < 32; i++) pval[i] = 0;
        end
        pbuf[a % 32] = d; pval[a % 32] = 1; mlast = d;
      end
      if (ale) mlo = ad_in;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare with the model on every clock, away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      chk({cur_req, " busy"}, {7'd0, busy}, {7'd0, mst == 2});
      chk({cur_req, " rd_data"}, rd_data, exp_rd);
    end
  end

  task automatic wr_byte(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); ale = 1; ad_in = a[7:0]; addr_hi = a[12:8];
    @(negedge clk); ale = 0; wr_stb = 1; ad_in = d;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rd_byte(input logic [12:0] a, output logic [7:0] q);
    @(negedge clk); ale = 1; ad_in = a[7:0]; addr_hi = a[12:8];
    @(negedge clk); ale = 0; rd_stb = 1;
    @(negedge clk); rd_stb = 0; q = rd_data;
  endtask

  task automatic rd_chk(input string tag, input logic [12:0] a, input logic [7:0] exp);
    logic [7:0] q;
    rd_byte(a, q);
    chk(tag, q, exp);
  endtask

  task automatic wait_done;
    repeat (W + 3) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic arm_seq;
    wr_byte(13'h1555, 8'hAA); wr_byte(13'h0AAA, 8'h55); wr_byte(13'h1555, 8'hA0);
  endtask

  task automatic lock_seq(input logic [7:0] op, input logic [7:0] m);
    wr_byte(13'h1555, 8'hAA); wr_byte(13'h0AAA, 8'h55); wr_byte(13'h1555, op);
    wr_byte(13'h1555, 8'hAA); wr_byte(13'h0AAA, 8'h55); wr_byte(13'h1555, m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 busy", {7'd0, busy}, 8'h00);

    // R3 / R2: plain writes land; upper address lines select the byte
    cur_req = "R3";
    wr_byte(13'h0123, 8'h5A); wait_done;
    wr_byte(13'h1123, 8'hA7); wait_done;
    wr_byte(13'h0060, 8'h77); wait_done;
    wr_byte(13'h0300, 8'h10); wait_done;
    wr_byte(13'h0800, 8'h21); wait_done;
    rd_chk("R3 read back", 13'h0123, 8'h5A);
    cur_req = "R2";
    rd_chk("R2 high lines", 13'h1123, 8'hA7);
    rd_chk("R2 low byte", 13'h0123, 8'h5A);

    // R4: page gathering, off-page write dropped
    cur_req = "R4";
    wr_byte(13'h0040, 8'h11); wr_byte(13'h005F, 8'h20);
    wr_byte(13'h0060, 8'h33); wr_byte(13'h005F, 8'h22);
    wait_done;
    rd_chk("R4 first", 13'h0040, 8'h11);
    rd_chk("R4 last wins", 13'h005F, 8'h22);
    rd_chk("R4 off page", 13'h0060, 8'h77);

    // R5: exact delays
    cur_req = "R5";
    wr_byte(13'h0100, 8'h01);
    n = 0;
    while (!busy && n < 1000) begin @(negedge clk); n++; end
    chk("R5 window", n[7:0], W[7:0]);
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
    chk("R5 prog time", n[7:0], P[7:0]);
    rd_chk("R5 stored", 13'h0100, 8'h01);

    // R6 / R7: toggle polling, writes during busy ignored
    cur_req = "R6";
    wr_byte(13'h0200, 8'hC3);
    repeat (W + 1) @(negedge clk);
    rd_chk("R6 poll 1", 13'h0000, 8'h83);
    rd_chk("R6 poll 2", 13'h0000, 8'hC3);
    cur_req = "R7";
    wr_byte(13'h0300, 8'h99);
    cur_req = "R6";
    rd_chk("R6 poll 3", 13'h0000, 8'h83);
    wait_done;
    cur_req = "R7";
    rd_chk("R7 busy write", 13'h0300, 8'h10);

    // R9 / R10: lock block 2
    cur_req = "R9";
    lock_seq(8'h80, 8'h04);
    wr_byte(13'h0800, 8'hEE); wait_done;
    rd_chk("R9 locked", 13'h0800, 8'h21);
    wr_byte(13'h0C00, 8'h31); wait_done;
    rd_chk("R9 other block", 13'h0C00, 8'h31);

    // R11: aborted sequence, mismatching write is ordinary
    cur_req = "R11";
    wr_byte(13'h1555, 8'hAA); wr_byte(13'h0345, 8'h12); wait_done;
    rd_chk("R11 abort", 13'h0345, 8'h12);

    // R8: protection
    cur_req = "R8";
    arm_seq; wr_byte(13'h0400, 8'h44); wait_done;
    rd_chk("R8 armed write", 13'h0400, 8'h44);
    wr_byte(13'h0400, 8'h55); wait_done;
    rd_chk("R8 unarmed ignored", 13'h0400, 8'h44);

    // R10: armed write into locked block discarded, arm kept
    cur_req = "R10";
    arm_seq; wr_byte(13'h0800, 8'h66); wait_done;
    rd_chk("R10 locked armed", 13'h0800, 8'h21);
    wr_byte(13'h0C01, 8'h32); wait_done;
    rd_chk("R10 arm kept", 13'h0C01, 8'h32);

    // R9: unlock
    cur_req = "R9";
    lock_seq(8'h40, 8'h04);
    arm_seq; wr_byte(13'h0800, 8'h67); wait_done;
    rd_chk("R9 unlocked", 13'h0800, 8'h67);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule